// File: doc/BRIEF.md
# Memory protection region checker

This block sits on the path from a processor's bus request to memory. It holds a small table of programmable regions. Each region has a base address, a size given as a power-of-two exponent, an enable bit, and four permission flags: read, write, instruction fetch, and whether unprivileged code may use it at all. For each request the block takes the address, the access kind and the privilege level. In the same cycle it decides whether the access may go ahead. A denied access has its write enable removed before it reaches memory.

Region membership is a masked tag compare. The low `size_exp` bits of the address and of the base are ignored, so a base that is not aligned to its size drops down to the size boundary below it. When regions overlap, the enabled matching region with the highest index decides. This lets a small no-access guard placed under a large read/write stack region catch the first byte an overflowing stack writes past its bottom.

Each denial raises a one-cycle fault pulse on the next cycle. The first faulting address is held in a sticky fault register until software clears it. Regions are programmed through a plain address/data/write-enable port.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset all regions are disabled, the global check enable is clear, `fault_valid` is 0, `fault_addr` is 0 and no request is aborted.
- R2: An address hits an enabled region when its bits above bit `size_exp-1` equal the same bits of the region base. The low base bits are ignored, so a base of 0x20000813 with exponent 5 covers 0x20000800 to 0x2000081F.
- R3: A size exponent written below 5 is stored as 5, so the smallest region is 32 bytes.
- R4: When several enabled regions hit, only the flags of the hit region with the highest index apply. With a no-access region at index 1 inside a read/write region at index 0, a write to the overlap is aborted. Swapping the two indices lets the same write through.
- R5: The access kind selects the flag that must be set: `req_kind` 0 read (and the unused code 3) needs the read flag, 1 write needs the write flag, 2 fetch needs the execute flag.
- R6: An unprivileged request (`req_priv`=0) that hits a region is also aborted unless that region's user flag is set. Privileged requests ignore the user flag.
- R7: With checks enabled, a request that hits no enabled region is allowed when privileged and aborted when unprivileged.
- R8: While the global check enable is clear, no request is aborted.
- R9: The decision is combinational. `req_abort` and `mem_wen` respond in the same cycle as the request. `mem_wen` is 0 while the request is aborted and otherwise equals `req_wen`.
- R10: `fault_pulse` is high for the one cycle after each aborted request. The first aborted address is captured in `fault_addr` and `fault_valid` is set. While `fault_valid` is set, later faults leave `fault_addr` unchanged, until a control write with bit 1 set clears `fault_valid`.
- R11: Configuration map: `cfg_addr` = {region index, sel[1:0]}. sel 0 writes the base. sel 1 writes the attributes: bit 0 enable, bit 1 read, bit 2 write, bit 3 execute, bit 4 user allowed, bits 12:8 size exponent. sel 2 is the control register, whatever the index: bit 0 is the global check enable, and writing bit 1 as 1 clears the fault flag. Writes with sel 3 are ignored.
- R12: While `req_valid` is 0, no abort and no fault are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register address {index, sel} |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | 1 for a privileged request |
| req_wen | input | 1 | Write enable from the requester |
| mem_wen | output | 1 | Write enable passed on to memory |
| req_abort | output | 1 | Request denied this cycle |
| fault_pulse | output | 1 | One-cycle fault indication after an abort |
| fault_valid | output | 1 | Sticky flag: a fault address is held |
| fault_addr | output | ADDR_W | First faulting address |

## Verification
`req_abort` and `mem_wen` are due in the cycle the request is presented. `fault_pulse`, `fault_valid` and `fault_addr` are due one clock edge later. A configuration write takes effect at the edge that ends its cycle. The bench drives each request on a falling edge and holds it for one cycle. Its scoreboard monitor compares the combinational results 2 ns after that same falling edge, and compares the fault pulse one cycle later at the same offset. Register results are read only after the driving task has returned past the capturing edge.

// File: rtl/mpu_guard_pkg.sv
// Shared types for the memory protection region checker.
// Assumes a byte-addressed bus and region sizes of at least 32 bytes.
package mpu_guard_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_SPARE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [4:0] size_exp;
        logic       user_ok;
        logic       exec_ok;
        logic       write_ok;
        logic       read_ok;
        logic       enable;
    } region_attr_t;

    localparam logic [4:0] MIN_SIZE_EXP = 5'd5;

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_ATTR = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int unsigned ATTR_EN_BIT   = 0;
    localparam int unsigned ATTR_RD_BIT   = 1;
    localparam int unsigned ATTR_WR_BIT   = 2;
    localparam int unsigned ATTR_EX_BIT   = 3;
    localparam int unsigned ATTR_USER_BIT = 4;
    localparam int unsigned ATTR_EXP_LSB  = 8;

    localparam int unsigned CTRL_GEN_BIT = 0;
    localparam int unsigned CTRL_CLR_BIT = 1;

endpackage

// File: rtl/mpu_region_bank.sv
// Region register file and control register.
// Decodes writes from the configuration port. Size exponents below the
// minimum are clamped on write. Writes with an unused selector are dropped.
// Assumes ADDR_W >= 13 so that the attribute fields fit in one data word.
module mpu_region_bank
    import mpu_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    parameter int unsigned CFG_AW      = IDX_W + 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [CFG_AW-1:0]                     cfg_addr,
    input  logic [ADDR_W-1:0]                     cfg_wdata,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]    base_q,
    output region_attr_t [NUM_REGIONS-1:0]        attr_q,
    output logic                                  glb_en,
    output logic                                  fault_clr
);

    logic [1:0]       wr_sel;
    logic [IDX_W-1:0] wr_idx;
    logic [4:0]       raw_exp;
    logic [4:0]       clamped_exp;
    region_attr_t     attr_new;

    assign wr_sel = cfg_addr[1:0];
    assign wr_idx = cfg_addr[CFG_AW-1:2];

    // Clamp the requested size exponent to the smallest legal region.
    always_comb begin
        raw_exp     = cfg_wdata[ATTR_EXP_LSB +: 5];
        clamped_exp = (raw_exp < MIN_SIZE_EXP) ? MIN_SIZE_EXP : raw_exp;
    end

    // Assemble the attribute word to be stored.
    always_comb begin
        attr_new.enable   = cfg_wdata[ATTR_EN_BIT];
        attr_new.read_ok  = cfg_wdata[ATTR_RD_BIT];
        attr_new.write_ok = cfg_wdata[ATTR_WR_BIT];
        attr_new.exec_ok  = cfg_wdata[ATTR_EX_BIT];
        attr_new.user_ok  = cfg_wdata[ATTR_USER_BIT];
        attr_new.size_exp = clamped_exp;
    end

    // Control register is shared by all indices; the clear bit is a pulse.
    assign fault_clr = cfg_we && (wr_sel == SEL_CTRL) && cfg_wdata[CTRL_CLR_BIT];

    // Hold the global check enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            glb_en <= 1'b0;
        else if (cfg_we && wr_sel == SEL_CTRL)
            glb_en <= cfg_wdata[CTRL_GEN_BIT];
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic hit_idx;
        assign hit_idx = cfg_we && (wr_idx == IDX_W'(g));

        // Store this region's base address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[g] <= '0;
            else if (hit_idx && wr_sel == SEL_BASE)
                base_q[g] <= cfg_wdata;
        end

        // Store this region's attributes; reset leaves it disabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                attr_q[g]          <= '0;
                attr_q[g].size_exp <= MIN_SIZE_EXP;
            end else if (hit_idx && wr_sel == SEL_ATTR) begin
                attr_q[g] <= attr_new;
            end
        end
    end

endmodule

// File: rtl/mpu_region_match.sv
// One region comparator: masked tag compare, no adder.
// The mask clears the low size_exp bits of both operands, so a misaligned
// base drops to its size boundary.
module mpu_region_match #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              enable,
    input  logic [4:0]        size_exp,
    output logic              hit
);

    logic [ADDR_W-1:0] tag_mask;
    logic [ADDR_W-1:0] diff;

    // Build the tag mask by shifting ones left; compare the tags only.
    always_comb begin
        tag_mask = {ADDR_W{1'b1}} << size_exp;
        diff     = (addr ^ base) & tag_mask;
        hit      = enable && (diff == '0);
    end

endmodule

// File: rtl/mpu_verdict.sv
// Picks the highest-index hit region and turns its flags into allow/abort.
// Purely combinational, so the decision lands in the request's own cycle.
// A miss is allowed for privileged requests only. A clear global enable
// allows everything.
module mpu_verdict
    import mpu_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4
) (
    input  logic [NUM_REGIONS-1:0]         hits,
    input  region_attr_t [NUM_REGIONS-1:0] attrs,
    input  logic                           req_valid,
    input  logic [1:0]                     req_kind,
    input  logic                           req_priv,
    input  logic                           glb_en,
    output logic                           abort
);

    acc_kind_e    kind;
    region_attr_t win_attr;
    logic         any_hit;
    logic         kind_ok;
    logic         allow;

    assign kind = acc_kind_e'(req_kind);

    // Later (higher) indices override earlier ones.
    always_comb begin
        win_attr = '0;
        any_hit  = 1'b0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                win_attr = attrs[i];
                any_hit  = 1'b1;
            end
        end
    end

    // Select the flag the access kind needs.
    always_comb begin
        unique case (kind)
            ACC_WRITE: kind_ok = win_attr.write_ok;
            ACC_FETCH: kind_ok = win_attr.exec_ok;
            default:   kind_ok = win_attr.read_ok;
        endcase
    end

    // Final decision.
    always_comb begin
        if (!glb_en)
            allow = 1'b1;
        else if (any_hit)
            allow = kind_ok && (req_priv || win_attr.user_ok);
        else
            allow = req_priv;
        abort = req_valid && !allow;
    end

endmodule

// File: rtl/mpu_fault_latch.sv
// Fault reporting: a one-cycle pulse after every abort and a sticky capture
// of the first faulting address. A fault that arrives with a clear is kept.
module mpu_fault_latch #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clr,
    output logic              fault_pulse,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr
);

    logic take;

    assign take = abort && (!fault_valid || clr);

    // Register the fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_pulse <= 1'b0;
        else
            fault_pulse <= abort;
    end

    // Sticky first-fault capture with software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_valid <= 1'b0;
            fault_addr  <= '0;
        end else if (take) begin
            fault_valid <= 1'b1;
            fault_addr  <= addr;
        end else if (clr) begin
            fault_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/mpu_region_guard.sv
// Top of the memory protection region checker.
// The region bank feeds one comparator per region. The verdict gates the
// write enable in the same cycle and the fault latch reports the abort.
// Assumes requests are single-cycle and the write enable may be gated
// combinationally.
module mpu_region_guard
    import mpu_guard_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    parameter int unsigned CFG_AW      = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    input  logic              req_wen,
    output logic              mem_wen,
    output logic              req_abort,
    output logic              fault_pulse,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr
);

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
    region_attr_t [NUM_REGIONS-1:0]     attr_q;
    logic [NUM_REGIONS-1:0]             hits;
    logic                               glb_en;
    logic                               fault_clr;

    mpu_region_bank #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W),
        .CFG_AW      (CFG_AW)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .attr_q    (attr_q),
        .glb_en    (glb_en),
        .fault_clr (fault_clr)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        mpu_region_match #(
            .ADDR_W (ADDR_W)
        ) i_match (
            .addr     (req_addr),
            .base     (base_q[g]),
            .enable   (attr_q[g].enable),
            .size_exp (attr_q[g].size_exp),
            .hit      (hits[g])
        );
    end

    mpu_verdict #(
        .NUM_REGIONS (NUM_REGIONS)
    ) i_verdict (
        .hits      (hits),
        .attrs     (attr_q),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_priv  (req_priv),
        .glb_en    (glb_en),
        .abort     (req_abort)
    );

    // Cancel the write before it reaches memory.
    assign mem_wen = req_wen && !req_abort;

    mpu_fault_latch #(
        .ADDR_W (ADDR_W)
    ) i_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (req_abort),
        .addr        (req_addr),
        .clr         (fault_clr),
        .fault_pulse (fault_pulse),
        .fault_valid (fault_valid),
        .fault_addr  (fault_addr)
    );

endmodule

// File: rtl/mpu_region_guard_chk.sv
// Property checker for the region checker, attached by bind.
module mpu_region_guard_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_wen,
    input logic              mem_wen,
    input logic              req_abort,
    input logic              fault_pulse,
    input logic              fault_valid,
    input logic [ADDR_W-1:0] fault_addr,
    input logic              glb_en,
    input logic              fault_clr
);

    AST_WEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_abort |-> !mem_wen);                                          // R9
    AST_WEN_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
        !req_abort |-> (mem_wen == req_wen));                             // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_abort);                                       // R12
    AST_BYPASS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !req_abort);                                          // R8
    AST_PULSE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        req_abort |=> fault_pulse);                                       // R10
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> $past(req_abort));                                // R10
    AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
        req_abort |=> fault_valid);                                       // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !fault_clr) |=> $stable(fault_addr));             // R10

endmodule

bind mpu_region_guard mpu_region_guard_chk #(
    .ADDR_W (ADDR_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_wen     (req_wen),
    .mem_wen     (mem_wen),
    .req_abort   (req_abort),
    .fault_pulse (fault_pulse),
    .fault_valid (fault_valid),
    .fault_addr  (fault_addr),
    .glb_en      (glb_en),
    .fault_clr   (fault_clr)
);

// File: tb/test_mpu_region_guard.sv
// Scoreboard bench: the driver queues expected results, the monitor checks them.
module test_mpu_region_guard;

    localparam int unsigned AW  = 32;
    localparam int unsigned CAW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic           req_valid = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [1:0]     req_kind = 2'd0;
    logic           req_priv = 1'b0;
    logic           req_wen = 1'b0;
    logic           mem_wen;
    logic           req_abort;
    logic           fault_pulse;
    logic           fault_valid;
    logic [AW-1:0]  fault_addr;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic  exp_abort;
        logic  exp_wen;
        logic  exp_pulse;
        string tag;
    } item_t;

    item_t q[$];

    always #4 clk = ~clk;

    mpu_region_guard i_mpu_region_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_kind    (req_kind),
        .req_priv    (req_priv),
        .req_wen     (req_wen),
        .mem_wen     (mem_wen),
        .req_abort   (req_abort),
        .fault_pulse (fault_pulse),
        .fault_valid (fault_valid),
        .fault_addr  (fault_addr)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] attr(input bit en, input bit rd, input bit wr,
                                           input bit ex, input bit usr, input int k);
        return AW'((k & 31) << 8) | AW'({usr, ex, wr, rd, en});
    endfunction

    function automatic logic [CAW-1:0] ca(input int idx, input int sel);
        return CAW'(((idx & 3) << 2) | (sel & 3));
    endfunction

    task automatic cfg_wr(input logic [CAW-1:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one request for one cycle and queue the expected result.
    task automatic req(input string tag, input bit vld, input logic [AW-1:0] a,
                       input logic [1:0] kind, input bit priv, input bit wen, input bit exp_ab);
        item_t it;
        @(negedge clk);
        req_valid = vld; req_addr = a; req_kind = kind; req_priv = priv; req_wen = wen;
        it.exp_abort = exp_ab;
        it.exp_wen   = wen && !exp_ab;
        it.exp_pulse = exp_ab;
        it.tag       = tag;
        q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0; req_wen = 1'b0;
    endtask

    // Monitor: combinational results in the request cycle, pulse one cycle later.
    initial begin
        bit    due = 1'b0;
        logic  due_val = 1'b0;
        string due_tag = "";
        forever begin
            @(negedge clk);
            #2;
            if (due) begin
                chk({due_tag, " R10 fault_pulse"}, AW'(fault_pulse), AW'(due_val));
                due = 1'b0;
            end
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk({it.tag, " R9 req_abort"}, AW'(req_abort), AW'(it.exp_abort));
                chk({it.tag, " R9 mem_wen"},   AW'(mem_wen),   AW'(it.exp_wen));
                due = 1'b1; due_val = it.exp_pulse; due_tag = it.tag;
            end
        end
    end

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [AW-1:0] STK = 32'h2000_0000;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R1 fault_valid after reset", AW'(fault_valid), '0);
        chk("R1 fault_addr after reset", fault_addr, '0);
        req("R1 R8 unpriv write with checks off", 1, STK, 2'd1, 0, 1, 0);

        // Stack 1 KB read/write at index 0, 32-byte no-access guard at index 1.
        cfg_wr(ca(0, 0), STK);
        cfg_wr(ca(0, 1), attr(1, 1, 1, 0, 1, 10));
        cfg_wr(ca(1, 0), STK);
        cfg_wr(ca(1, 1), attr(1, 0, 0, 0, 0, 5));
        cfg_wr(ca(0, 2), 32'h1);

        req("R5 write inside stack", 1, STK + 32'h100, 2'd1, 1, 1, 0);
        req("R4 write into guard", 1, STK + 32'h1F, 2'd1, 1, 1, 1);
        @(negedge clk); #2;
        chk("R10 first fault address", fault_addr, STK + 32'h1F);
        chk("R10 fault_valid set", AW'(fault_valid), 32'h1);
        req("R4 read into guard", 1, STK + 32'h10, 2'd0, 1, 0, 1);
        @(negedge clk); #2;
        chk("R10 address held on later fault", fault_addr, STK + 32'h1F);
        cfg_wr(ca(0, 2), 32'h3);
        #2;
        chk("R10 clear drops fault_valid", AW'(fault_valid), '0);

        req("R6 unpriv read with user flag", 1, STK + 32'h200, 2'd0, 0, 0, 0);
        req("R5 fetch without exec flag", 1, STK + 32'h200, 2'd2, 1, 0, 1);
        @(negedge clk); #2;
        chk("R10 new capture after clear", fault_addr, STK + 32'h200);
        req("R5 spare kind uses read flag", 1, STK + 32'h200, 2'd3, 1, 0, 0);
        req("R7 priv miss allowed", 1, 32'h3000_0000, 2'd0, 1, 0, 0);
        req("R7 unpriv miss denied", 1, 32'h3000_0000, 2'd0, 0, 0, 1);

        // Swap indices: the broad region now wins over the guard.
        cfg_wr(ca(0, 1), attr(1, 0, 0, 0, 0, 5));
        cfg_wr(ca(1, 1), attr(1, 1, 1, 0, 1, 10));
        req("R4 swapped indices allow guard write", 1, STK + 32'h1F, 2'd1, 1, 1, 0);

        // Misaligned base snaps down to 0x20000800, read-only, privileged only.
        cfg_wr(ca(2, 0), 32'h2000_0813);
        cfg_wr(ca(2, 1), attr(1, 1, 0, 0, 0, 5));
        req("R2 write at snapped start", 1, 32'h2000_0800, 2'd1, 1, 1, 1);
        req("R2 write at snapped end", 1, 32'h2000_081F, 2'd1, 1, 1, 1);
        req("R2 write past region", 1, 32'h2000_0820, 2'd1, 1, 1, 0);
        req("R2 read at snapped start", 1, 32'h2000_0800, 2'd0, 1, 0, 0);
        req("R6 unpriv read without user flag", 1, 32'h2000_0800, 2'd0, 0, 0, 1);

        // Exponent 2 is clamped to 5.
        cfg_wr(ca(3, 0), 32'h2000_1000);
        cfg_wr(ca(3, 1), attr(1, 0, 0, 0, 0, 2));
        req("R3 clamped region covers byte 0x1F", 1, 32'h2000_101F, 2'd1, 1, 1, 1);
        req("R3 clamped region ends at 0x20", 1, 32'h2000_1020, 2'd1, 1, 1, 0);

        // Sel 3 write is dropped: region 3 must be unchanged.
        cfg_wr(ca(3, 3), 32'h0);
        req("R11 sel 3 ignored", 1, 32'h2000_1000, 2'd1, 1, 1, 1);

        req("R12 idle request in guard", 0, 32'h2000_1000, 2'd1, 0, 1, 0);

        cfg_wr(ca(2, 2), 32'h0);
        req("R8 global off unpriv write", 1, 32'h2000_1000, 2'd1, 0, 1, 0);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule